// File: doc/BRIEF.md
# Expansion ROM Window and Interrupt Config Registers

This block implements four entries at the upper end of a PCI Type 0 configuration header: the expansion ROM base register, the capabilities pointer, and the interrupt line and interrupt pin registers. Configuration requests arrive dword-aligned, as a dword index with four byte enables. Writes take effect on the clock edge. Read data is returned one cycle after the request, together with a valid flag.

The block also decodes memory addresses for the ROM window. It receives the Memory Space enable from the Command register and two strap inputs that stand for EEPROM-loaded settings: one says whether a ROM is fitted, the other whether power management is offered. For each 32-bit memory address it reports whether the address hits the 1 MB ROM window, and it gives the offset of the address inside that window.

Top module: `romcfg_slice`

## Requirements
- R1: The ROM base register (dword index 12, byte offset 0x30) stores only address bits 31:20. Writing 0xFFFFFFFE reads back as 0xFFF00000, which tells software the window is 1 MB.
- R2: Bits 19:1 of the ROM base register always read as zero.
- R3: Bit 0 of the ROM base register is the decode enable. It is read/write, and the whole register resets to zero.
- R4: romHit is 1 only when all four of these hold: memSpaceEn is 1, the decode enable is 1, the ROM strap is 1, and memAddr[31:20] equals the stored base. While romHit is 1, romOffset equals memAddr[19:0]. Otherwise romOffset is zero.
- R5: While romPresentStrap is 0, the ROM base register reads as zero, writes to it are ignored (its stored value is unchanged), and romHit stays 0.
- R6: The capabilities pointer occupies byte 0 of dword index 13 (offset 0x34) and is read-only. It reads 0xDC when pmStrap is 1 and 0x00 when pmStrap is 0. The other bytes of that dword read zero.
- R7: The interrupt line is byte 0 of dword index 15 (offset 0x3C). It is read/write and resets to 0x00.
- R8: The interrupt pin is byte 1 of dword index 15, is read-only and always reads 0x01. Bytes 3:2 of that dword read zero.
- R9: A write updates only the bytes whose byte enable is 1. For the ROM register, byte enable 0 controls bit 0, byte enable 2 controls bits 23:20 and byte enable 3 controls bits 31:24.
- R10: A read of any other dword index (for example 14, offset 0x38) returns zero, and writes to such indices change nothing.
- R11: cfgRdValid is 1 exactly one cycle after cfgRdEn was 1, and cfgRdData carries the read result in that cycle. At all other times cfgRdData is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAddr | input | 6 | Configuration dword index (byte address bits 7:2) |
| cfgWrEn | input | 1 | Configuration write request |
| cfgRdEn | input | 1 | Configuration read request |
| cfgByteEn | input | 4 | Byte enables for the write |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data, valid with cfgRdValid |
| cfgRdValid | output | 1 | Read data valid, one cycle after cfgRdEn |
| memSpaceEn | input | 1 | Memory Space bit from the Command register |
| romPresentStrap | input | 1 | ROM fitted |
| pmStrap | input | 1 | Power management offered |
| memAddr | input | 32 | Memory address to decode |
| romHit | output | 1 | Address falls inside the enabled ROM window |
| romOffset | output | 20 | Offset of the address inside the ROM window |

## Verification
The hardest case to reach from the ports is a write that arrives while the ROM strap is low. A read at that time returns zero whether or not the write was dropped, so the read alone cannot show the difference. The stimulus therefore first programs a known base and enable, then lowers the strap, writes zeros, and checks that the read and the hit are suppressed. It then raises the strap again and reads back the original value and the original hit. Partial byte-enable writes are covered in the same way: each one is followed by a full read-back, so every lane is checked on its own.

// File: rtl/romcfg_pkg.sv
package romcfg_pkg;
  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_ROM  = 2'd1,
    RD_CAP  = 2'd2,
    RD_INT  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic       romEnWr;    // lane 0: decode enable
    logic [1:0] romBaseWr;  // lanes 3,2: base bits 31:24, 23:20
    logic       intLineWr;  // lane 0 of interrupt dword
    logic       rdStrobe;
    rdSel_e     rdSel;
  } cfgStrb_t;
endpackage

// File: rtl/romcfg_ctrl.sv
module romcfg_ctrl
  import romcfg_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int ROM_IDX = 12,
  parameter int CAP_IDX = 13,
  parameter int INT_IDX = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              cfgWrEn,
  input  logic              cfgRdEn,
  input  logic [3:0]        cfgByteEn,
  input  logic              romPresentStrap,
  output cfgStrb_t          strb
);
  logic isRom, isCap, isInt;
  logic romWrOk;

  always_comb begin
    isRom   = (cfgAddr == ADDR_W'(ROM_IDX));
    isCap   = (cfgAddr == ADDR_W'(CAP_IDX));
    isInt   = (cfgAddr == ADDR_W'(INT_IDX));
    romWrOk = cfgWrEn && isRom && romPresentStrap;

    strb           = '0;
    strb.romEnWr   = romWrOk && cfgByteEn[0];
    strb.romBaseWr = romWrOk ? cfgByteEn[3:2] : 2'b00;
    strb.intLineWr = cfgWrEn && isInt && cfgByteEn[0];
    strb.rdStrobe  = cfgRdEn;
    if (isRom && romPresentStrap) strb.rdSel = RD_ROM;
    else if (isCap)               strb.rdSel = RD_CAP;
    else if (isInt)               strb.rdSel = RD_INT;
    else                          strb.rdSel = RD_ZERO;
  end

  // Each write strobe needs its own byte enable.
  assert_lanes_follow_be_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.romBaseWr & ~cfgByteEn[3:2]) == 2'b00 && (!strb.romEnWr || cfgByteEn[0]));

  // A write reaches at most one register.
  assert_single_target_R10: assert property (@(posedge clk) disable iff (!rstN)
    !((strb.romEnWr || strb.romBaseWr != 2'b00) && strb.intLineWr));
endmodule

// File: rtl/romcfg_dp.sv
module romcfg_dp
  import romcfg_pkg::*;
#(
  parameter int         WIN_LOG2 = 20,
  parameter logic [7:0] CAP_PTR  = 8'hDC,
  parameter logic [7:0] INT_PIN  = 8'h01
) (
  input  logic                clk,
  input  logic                rstN,
  input  cfgStrb_t            strb,
  input  logic [31:0]         cfgWrData,
  input  logic                memSpaceEn,
  input  logic                romPresentStrap,
  input  logic                pmStrap,
  input  logic [31:0]         memAddr,
  output logic [31:0]         cfgRdData,
  output logic                cfgRdValid,
  output logic                romHit,
  output logic [WIN_LOG2-1:0] romOffset
);
  localparam int BASE_W = 32 - WIN_LOG2;
  localparam int LOW_W  = BASE_W - 8;

  logic [BASE_W-1:0] romBaseQ;
  logic              romEnQ;
  logic [7:0]        intLineQ;
  logic [31:0]       rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romBaseQ <= '0;
      romEnQ   <= 1'b0;
      intLineQ <= 8'h00;
    end else begin
      if (strb.romEnWr)      romEnQ             <= cfgWrData[0];
      if (strb.romBaseWr[1]) romBaseQ[BASE_W-1 -: 8] <= cfgWrData[31:24];
      if (strb.romBaseWr[0]) romBaseQ[LOW_W-1:0]     <= cfgWrData[23:WIN_LOG2];
      if (strb.intLineWr)    intLineQ           <= cfgWrData[7:0];
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_ROM:  rdNext = {romBaseQ, {(WIN_LOG2-1){1'b0}}, romEnQ};
      RD_CAP:  rdNext = {24'h0, pmStrap ? CAP_PTR : 8'h00};
      RD_INT:  rdNext = {16'h0, INT_PIN, intLineQ};
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgRdValid <= 1'b0;
      cfgRdData  <= '0;
    end else begin
      cfgRdValid <= strb.rdStrobe;
      cfgRdData  <= strb.rdStrobe ? rdNext : '0;
    end
  end

  always_comb begin
    romHit    = romPresentStrap && memSpaceEn && romEnQ &&
                (memAddr[31:WIN_LOG2] == romBaseQ);
    romOffset = romHit ? memAddr[WIN_LOG2-1:0] : '0;
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.rdStrobe && strb.rdSel == RD_ROM) |-> cfgRdData[WIN_LOG2-1:1] == '0);

  assert_enable_from_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(romEnQ) |-> $past(strb.romEnWr && cfgWrData[0]));

  assert_absent_no_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    !romPresentStrap |-> !strb.romEnWr && strb.romBaseWr == 2'b00);

  assert_line_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.intLineWr) |-> $stable(intLineQ));

  assert_valid_timing_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdStrobe |=> cfgRdValid);

  assert_hit_offset_R4: assert property (@(posedge clk) disable iff (!rstN)
    !romHit |-> romOffset == '0);

  assert_wrdata_lanes_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.intLineWr |=> intLineQ == $past(cfgWrData[7:0]) || $past(cfgWrData[19:8]) != 12'h0
                       || intLineQ == $past(cfgWrData[7:0]));
endmodule

// File: rtl/romcfg_slice.sv
module romcfg_slice
  import romcfg_pkg::*;
#(
  parameter int         ADDR_W   = 6,
  parameter int         WIN_LOG2 = 20,
  parameter int         ROM_IDX  = 12,
  parameter int         CAP_IDX  = 13,
  parameter int         INT_IDX  = 15,
  parameter logic [7:0] CAP_PTR  = 8'hDC,
  parameter logic [7:0] INT_PIN  = 8'h01
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic                cfgWrEn,
  input  logic                cfgRdEn,
  input  logic [3:0]          cfgByteEn,
  input  logic [31:0]         cfgWrData,
  output logic [31:0]         cfgRdData,
  output logic                cfgRdValid,
  input  logic                memSpaceEn,
  input  logic                romPresentStrap,
  input  logic                pmStrap,
  input  logic [31:0]         memAddr,
  output logic                romHit,
  output logic [WIN_LOG2-1:0] romOffset
);
  cfgStrb_t strb;

  romcfg_ctrl #(
    .ADDR_W(ADDR_W), .ROM_IDX(ROM_IDX), .CAP_IDX(CAP_IDX), .INT_IDX(INT_IDX)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWrEn(cfgWrEn),
    .cfgRdEn(cfgRdEn), .cfgByteEn(cfgByteEn),
    .romPresentStrap(romPresentStrap), .strb(strb)
  );

  romcfg_dp #(
    .WIN_LOG2(WIN_LOG2), .CAP_PTR(CAP_PTR), .INT_PIN(INT_PIN)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWrData(cfgWrData),
    .memSpaceEn(memSpaceEn), .romPresentStrap(romPresentStrap), .pmStrap(pmStrap),
    .memAddr(memAddr), .cfgRdData(cfgRdData), .cfgRdValid(cfgRdValid),
    .romHit(romHit), .romOffset(romOffset)
  );
endmodule

// File: tb/romcfg_slice_tb.sv
module romcfg_slice_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic        cfgWrEn = 1'b0;
  logic        cfgRdEn = 1'b0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        cfgRdValid;
  logic        memSpaceEn = 1'b0;
  logic        romPresentStrap = 1'b1;
  logic        pmStrap = 1'b1;
  logic [31:0] memAddr = '0;
  logic        romHit;
  logic [19:0] romOffset;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  romcfg_slice dut_i (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .cfgRdValid(cfgRdValid), .memSpaceEn(memSpaceEn), .romPresentStrap(romPresentStrap),
    .pmStrap(pmStrap), .memAddr(memAddr), .romHit(romHit), .romOffset(romOffset)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as the design returns it.
  always @(negedge clk) begin
    if (rstN && cfgRdValid) begin
      if (expQ.size() == 0) check(1'b0, "R11 unexpected valid", cfgRdData, 32'h0);
      else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(cfgRdData === e, t, cfgRdData, e);
      end
    end else if (rstN) begin
      check(cfgRdData === 32'h0, "R11 data zero when idle", cfgRdData, 32'h0);
    end
  end

  task automatic cfgWrite(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfgAddr = idx; cfgByteEn = be; cfgWrData = d; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = '0;
  endtask

  task automatic cfgRead(input logic [5:0] idx, input logic [31:0] e, input string tag);
    @(negedge clk);
    cfgAddr = idx; cfgRdEn = 1'b1;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    cfgRdEn = 1'b0;
  endtask

  task automatic checkHit(input logic [31:0] a, input bit eHit, input logic [19:0] eOff,
                          input string tag);
    @(negedge clk);
    memAddr = a;
    #1;
    check(romHit === eHit, {tag, " hit"}, {31'h0, romHit}, {31'h0, eHit});
    check(romOffset === eOff, {tag, " offset"}, {12'h0, romOffset}, {12'h0, eOff});
  endtask

  initial begin : watchdog
    #200000;
    check(1'b0, "watchdog expired", 32'h0, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    cfgRead(6'd12, 32'h0000_0000, "R3 rom reg reset");
    cfgRead(6'd15, 32'h0000_0100, "R7 R8 int reset");
    cfgRead(6'd13, 32'h0000_00DC, "R6 cap with pm");
    // sizing
    cfgWrite(6'd12, 4'hF, 32'hFFFF_FFFE);
    cfgRead(6'd12, 32'hFFF0_0000, "R1 R2 sizing readback");
    cfgWrite(6'd12, 4'hF, 32'h1234_5679);
    cfgRead(6'd12, 32'h1230_0001, "R1 R3 base and enable");
    memSpaceEn = 1'b1;
    checkHit(32'h123A_BCDE, 1'b1, 20'hABCDE, "R4 inside window");
    checkHit(32'h1240_0000, 1'b0, 20'h0, "R4 above window");
    checkHit(32'h122F_FFFF, 1'b0, 20'h0, "R4 below window");
    memSpaceEn = 1'b0;
    checkHit(32'h1230_0004, 1'b0, 20'h0, "R4 memspace off");
    memSpaceEn = 1'b1;
    cfgWrite(6'd12, 4'h1, 32'h0000_0000);
    cfgRead(6'd12, 32'h1230_0000, "R3 enable cleared");
    checkHit(32'h1230_0004, 1'b0, 20'h0, "R4 rom enable off");
    // byte lanes
    cfgWrite(6'd12, 4'h8, 32'hAB00_0000);
    cfgRead(6'd12, 32'hAB30_0000, "R9 lane3 only");
    cfgWrite(6'd12, 4'h4, 32'h00FF_0000);
    cfgRead(6'd12, 32'hABF0_0000, "R9 lane2 only");
    cfgWrite(6'd12, 4'h2, 32'hFFFF_FFFF);
    cfgRead(6'd12, 32'hABF0_0000, "R9 R2 lane1 no effect");
    cfgWrite(6'd12, 4'h1, 32'h0000_0001);
    cfgRead(6'd12, 32'hABF0_0001, "R9 lane0 enable");
    checkHit(32'hABF0_0000, 1'b1, 20'h00000, "R4 window start");
    checkHit(32'hABFF_FFFF, 1'b1, 20'hFFFFF, "R4 window end");
    checkHit(32'hABEF_FFFF, 1'b0, 20'h0, "R4 just below");
    // interrupt registers
    cfgWrite(6'd15, 4'hF, 32'hFFFF_FF5A);
    cfgRead(6'd15, 32'h0000_015A, "R7 R8 line written pin fixed");
    cfgWrite(6'd15, 4'hE, 32'h0000_0077);
    cfgRead(6'd15, 32'h0000_015A, "R9 R7 line lane off");
    // capabilities
    cfgWrite(6'd13, 4'hF, 32'hFFFF_FFFF);
    cfgRead(6'd13, 32'h0000_00DC, "R6 cap read-only");
    pmStrap = 1'b0;
    cfgRead(6'd13, 32'h0000_0000, "R6 cap without pm");
    pmStrap = 1'b1;
    // unimplemented dwords
    cfgWrite(6'd14, 4'hF, 32'hFFFF_FFFF);
    cfgRead(6'd14, 32'h0000_0000, "R10 offset 0x38 zero");
    cfgWrite(6'd0, 4'hF, 32'hFFFF_FFFF);
    cfgRead(6'd0, 32'h0000_0000, "R10 index 0 zero");
    cfgRead(6'd12, 32'hABF0_0001, "R10 rom untouched");
    cfgRead(6'd15, 32'h0000_015A, "R10 int untouched");
    // ROM strap absent
    romPresentStrap = 1'b0;
    cfgRead(6'd12, 32'h0000_0000, "R5 absent reads zero");
    checkHit(32'hABF0_0010, 1'b0, 20'h0, "R5 absent no hit");
    cfgWrite(6'd12, 4'hF, 32'h0000_0000);
    romPresentStrap = 1'b1;
    cfgRead(6'd12, 32'hABF0_0001, "R5 absent write ignored");
    checkHit(32'hABF0_0010, 1'b1, 20'h00010, "R5 hit restored");
    // drain and idle check
    repeat (3) @(negedge clk);
    check(cfgRdValid === 1'b0, "R11 valid low when idle", {31'h0, cfgRdValid}, 32'h0);
    check(expQ.size() == 0, "R11 all reads returned", expQ.size(), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule